// File: doc/BRIEF.md
# Two-Wire EEPROM Byte-Write Slave

This block is the slave end of a two-wire serial memory that holds a 2048 x 8 byte array. It watches oversampled clock and data lines from the bus. It detects start and stop conditions and decodes the addressing byte that follows a start. It answers a matching byte with an acknowledge, driven through an open-drain pull-low enable. A byte write carries three bytes: the addressing byte, a word address and one data byte. The array is written only once the master closes that sequence with a stop.

The addressing byte is laid out MSB first as follows:
- bit 7: device-type marker, which must be 1.
- bits 6..4: device select.
- bits 3..1: the upper part of the array address.
- bit 0: the direction.

Three strap inputs give each part its own select code, so eight parts can share one bus. After the stop, a write timer runs for a fixed number of system clocks. During that time the slave gives no response to anything on the bus. A plain combinational lookup port lets the surrounding logic read any array byte.

The bus side is bit-serial and has no back-pressure. The slave never stretches the clock, so nothing on it takes the form of valid/ready. Every pin is a plain level.

Top module: `twi_eeprom_bytewr`

## Requirements
- R1: After reset the pull-low enable and busy are low, the slave is idle, and every array byte reads 0x00.
- R2: Both lines pass through two synchronizing flops. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. An SDA fall while SCL is low does not begin address decode.
- R3: The addressing byte matches only when bit 7 is 1, bit 6 equals strap[2], bit 5 equals the inverse of strap[1], and bit 4 equals strap[0]. A mismatch gets no acknowledge, and the slave waits for the next start.
- R4: The pull-low enable rises only on the SCL falling edge that opens the ninth clock of a byte. It falls on the next SCL falling edge, or on a start, stop or busy abort. It is never high during the eighth data clock.
- R5: In a write (bit 0 = 0), the slave acknowledges the addressing byte, the word address and the data byte. The target location is {addressing byte bits 3..1, word address}, which is 11 bits.
- R6: The array changes only when a stop follows a fully acknowledged data byte. A stop or restart placed earlier drops the partial transfer and changes nothing.
- R7: busy goes high the second clock after the stop is detected and stays high for exactly WRITE_CYCLES clocks. The array byte takes its new value on the edge where busy falls, and keeps its old value before that edge.
- R8: While busy is high the slave ignores starts, stops and address bytes and never acknowledges. After busy falls it responds normally.
- R9: A matching byte with bit 0 = 1 is acknowledged. The slave then releases the bus and goes idle without changing the array.
- R10: An SCL clock that completes after the acknowledged data byte and before the stop cancels the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_sel | input | 3 | Board straps giving this part's select code |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_addr | input | 11 | Array lookup address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
Assertions check on every cycle that the pull-low enable only changes on an SCL falling edge or an abort event. They also check that it stays low whenever busy is high, that busy only rises after a commit request, and that no commit request arrives while busy. Address matching over every strap and select pairing, the 11-bit address composition, the exact busy length, and the cases where the array stays unchanged (early stop, restart, an extra clock, a read byte) can only be shown by the bench's bus scenarios and its final array sweep.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 3;
  localparam int ADDR_W = HI_W + BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_ACK_ARM,
    PH_ACK_DRIVE,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    FLD_DEV,
    FLD_WORD,
    FLD_DATA
  } field_t;
endpackage

// File: rtl/eepw_line_sync.sv
module eepw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // R2: conditions only count with SCL held high across the SDA change
  assign start_det = sda_q & ~sda_s & scl_s & scl_q;
  assign stop_det  = ~sda_q & sda_s & scl_s & scl_q;
endmodule

// File: rtl/eepw_proto.sv
module eepw_proto
  import eepw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap_sel,
  input  logic              busy_i,
  output logic              sda_pull,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTE_W-1:0] commit_data
);
  phase_t             phase;
  field_t             field;
  logic [2:0]         bit_cnt;
  logic [BYTE_W-1:0]  shreg, nxt_byte, word_q, data_q;
  logic [HI_W-1:0]    hi_q;
  logic               rd_q, dev_hit;

  assign nxt_byte = {shreg[BYTE_W-2:0], sda_s};
  // R3: type bit set, middle select bit inverted against its strap
  assign dev_hit  = nxt_byte[7] && (nxt_byte[6] == strap_sel[2]) &&
                    (nxt_byte[5] == ~strap_sel[1]) && (nxt_byte[4] == strap_sel[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      field    <= FLD_DEV;
      bit_cnt  <= '0;
      shreg    <= '0;
      word_q   <= '0;
      data_q   <= '0;
      hi_q     <= '0;
      rd_q     <= 1'b0;
      sda_pull <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (busy_i) begin
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        phase    <= PH_SHIFT;
        field    <= FLD_DEV;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        commit_o <= (phase == PH_HOLD);
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (phase)
          PH_SHIFT: if (scl_rise) begin
            shreg <= nxt_byte;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              unique case (field)
                FLD_DEV: begin
                  if (dev_hit) begin
                    hi_q  <= nxt_byte[HI_W:1];
                    rd_q  <= nxt_byte[0];
                    phase <= PH_ACK_ARM;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                FLD_WORD: begin
                  word_q <= nxt_byte;
                  phase  <= PH_ACK_ARM;
                end
                default: begin
                  data_q <= nxt_byte;
                  phase  <= PH_ACK_ARM;
                end
              endcase
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          PH_ACK_ARM: if (scl_fall) begin
            sda_pull <= 1'b1;
            phase    <= PH_ACK_DRIVE;
          end
          PH_ACK_DRIVE: if (scl_fall) begin
            sda_pull <= 1'b0;
            if (field == FLD_DATA) begin
              phase <= PH_HOLD;
            end else if (field == FLD_DEV && rd_q) begin
              phase <= PH_IDLE;
            end else begin
              field <= (field == FLD_DEV) ? FLD_WORD : FLD_DATA;
              phase <= PH_SHIFT;
            end
          end
          // R10: a completed extra clock before the stop drops the write
          PH_HOLD: if (scl_fall) phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign commit_addr = {hi_q, word_q};
  assign commit_data = data_q;

  assert_pull_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  assert_pull_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det || busy_i));
endmodule

// File: rtl/eepw_store.sv
module eepw_store
  import eepw_pkg::*;
#(
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [BYTE_W-1:0] commit_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] pend_addr;
  logic [BYTE_W-1:0] pend_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
      if (remain == CNT_W'(1)) mem[pend_addr] <= pend_data;
    end else if (commit_i) begin
      remain    <= CNT_W'(WRITE_CYCLES);
      pend_addr <= commit_addr;
      pend_data <= commit_data;
    end
  end

  assign busy_o  = (remain != '0);
  assign rd_data = mem[rd_addr];

  assert_busy_from_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i));
  assert_commit_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !busy_o);
endmodule

// File: rtl/twi_eeprom_bytewr.sv
module twi_eeprom_bytewr
  import eepw_pkg::*;
#(
  parameter int WRITE_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap_sel,
  output logic              sda_pull_o,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [BYTE_W-1:0] commit_data;

  eepw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eepw_proto proto_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_sel(strap_sel), .busy_i(busy_o), .sda_pull(sda_pull_o),
    .commit_o(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  eepw_store #(.WRITE_CYCLES(WRITE_CYCLES)) store_i (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy_o(busy_o)
  );

  assert_silent_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);
endmodule

// File: tb/twi_eeprom_bytewr_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_bytewr_tb_top;
  localparam int WC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'd0;
  logic        pull, busy;
  logic [10:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [7:0]  model [2048];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twi_eeprom_bytewr #(.WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_m & ~pull),
    .strap_sel(strap), .sda_pull_o(pull), .busy_o(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2); scl = 1'b1; tick(4);
    sda_m = 1'b0; tick(4); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(2); sda_m = 1'b0; tick(2);
    scl = 1'b1; tick(4); sda_m = 1'b1; tick(1);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; tick(2); sda_m = b; tick(2); scl = 1'b1; tick(4);
  endtask

  task automatic send_byte_ack(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    chk("R4 no pull in eighth clock", pull, 1'b0);
    scl = 1'b0; tick(2); sda_m = 1'b1; tick(4);
    scl = 1'b1; tick(2); acked = pull; tick(2);
    scl = 1'b0; tick(6);
    chk("R4 pull released after ninth clock", pull, 1'b0);
  endtask

  task automatic write_frame(input logic [7:0] dev, input logic [7:0] word, input logic [7:0] dat);
    logic a;
    bus_start();
    send_byte_ack(dev, a);  chk("R5 addressing byte ack", a, 1'b1);
    send_byte_ack(word, a); chk("R5 word address ack", a, 1'b1);
    send_byte_ack(dat, a);  chk("R5 data byte ack", a, 1'b1);
  endtask

  task automatic wait_busy_rise();
    int n = 0;
    while (!busy && n < 12) begin tick(1); n++; end
    chk("R6 commit after stop", busy, 1'b1);
  endtask

  task automatic measure_commit(input logic [10:0] addr, input logic [7:0] dat);
    int len = 0;
    wait_busy_rise();
    chk("R7 old value while busy", rd_data, model[addr]);
    while (busy && len < WC + 20) begin len++; tick(1); end
    chk("R7 busy length", len, WC);
    chk("R5 stored byte", rd_data, dat);
    model[addr] = dat;
  endtask

  task automatic expect_no_commit(input string req, input logic [10:0] addr);
    tick(20);
    chk(req, busy, 1'b0);
    chk(req, rd_data, model[addr]);
  endtask

  initial begin
    logic a;
    logic [7:0] dev, word, dat;
    logic [2:0] hi, sel;
    logic [10:0] addr;
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(3);
    // R1 reset state
    chk("R1 pull after reset", pull, 1'b0);
    chk("R1 busy after reset", busy, 1'b0);
    rd_addr = 11'd0; tick(1); chk("R1 array zero", rd_data, 8'h00);
    rd_addr = 11'h7FF; tick(1); chk("R1 array zero", rd_data, 8'h00);

    // R3 / R5 / R7: every strap against every select code
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        strap = 3'(s);
        sel = 3'(d);
        hi = 3'(s) ^ 3'(d) ^ 3'b101;
        dev = {1'b1, sel, hi, 1'b0};
        if (sel == (strap ^ 3'b010)) begin
          word = 8'(s * 32 + d * 5 + 3);
          dat = 8'(s * 19 + 7 + int'(hi));
          addr = {hi, word};
          write_frame(dev, word, dat);
          rd_addr = addr;
          bus_stop();
          measure_commit(addr, dat);
        end else begin
          bus_start();
          send_byte_ack(dev, a);
          chk("R3 mismatch not acked", a, 1'b0);
          bus_stop();
          tick(4);
          chk("R3 mismatch no busy", busy, 1'b0);
        end
      end
    end

    strap = 3'b011;
    sel = 3'b001;
    // R3 type bit clear
    bus_start(); send_byte_ack({1'b0, sel, 3'b000, 1'b0}, a);
    chk("R3 type bit zero not acked", a, 1'b0); bus_stop(); tick(4);

    // R2 SDA fall while SCL low is not a start
    scl = 1'b0; tick(2); sda_m = 1'b1; tick(2); sda_m = 1'b0; tick(2);
    send_byte_ack({1'b1, sel, 3'b000, 1'b0}, a);
    chk("R2 no start without SCL high", a, 1'b0);
    bus_stop(); tick(4);

    // R6 restart after data byte aborts
    addr = {3'b110, 8'h5A}; rd_addr = addr;
    write_frame({1'b1, sel, 3'b110, 1'b0}, 8'h5A, 8'hC3);
    bus_start(); bus_stop();
    expect_no_commit("R6 restart aborts", addr);
    // R6 stop after word address only
    bus_start(); send_byte_ack({1'b1, sel, 3'b110, 1'b0}, a);
    send_byte_ack(8'h5A, a); bus_stop();
    expect_no_commit("R6 early stop", addr);

    // R10 extra clock before stop
    write_frame({1'b1, sel, 3'b110, 1'b0}, 8'h5A, 8'h3C);
    send_bit(1'b1); bus_stop();
    expect_no_commit("R10 extra clock cancels", addr);

    // R9 read direction acked, then bus released
    bus_start(); send_byte_ack({1'b1, sel, 3'b110, 1'b1}, a);
    chk("R9 read byte acked", a, 1'b1);
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1);
      chk("R9 bus released after read ack", pull, 1'b0);
    end
    bus_stop();
    expect_no_commit("R9 read leaves array", addr);

    // R8 deaf while busy, responsive afterwards
    write_frame({1'b1, sel, 3'b110, 1'b0}, 8'h5A, 8'h96);
    bus_stop();
    wait_busy_rise();
    bus_start(); send_byte_ack({1'b1, sel, 3'b010, 1'b0}, a);
    chk("R8 no ack while busy", a, 1'b0);
    chk("R8 still busy", busy, 1'b1);
    bus_stop();
    while (busy) tick(1);
    chk("R8 first write kept", rd_data, 8'h96);
    model[addr] = 8'h96;
    addr = {3'b010, 8'h11}; rd_addr = addr;
    write_frame({1'b1, sel, 3'b010, 1'b0}, 8'h11, 8'h77);
    bus_stop();
    measure_commit(addr, 8'h77);

    // full array sweep against the model
    for (int i = 0; i < 2048; i++) begin
      rd_addr = 11'(i); tick(1);
      chk("R5 R7 array sweep", rd_data, model[i]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule